// File: doc/BRIEF.md
# Paged Address Memory Mapper

This block widens a 16-bit processor address into a 24-bit physical address by page translation. The processor space is cut into sixteen 4 KB pages. The top four address bits pick one of sixteen 12-bit translation entries. When translation is on, that entry takes the place of those four bits. The 12-bit page offset always passes through as it is.

The processor programs the mapper through an 8-bit write bus that has two separate selects. One select loads a translation entry, and the entry number comes from the low address bits. The other select loads a one-bit control word that turns translation on or off. The load path is 8 bits wide, so entries hold an 8-bit page number and the top four bits of each entry stay zero. The physical space that can be reached is therefore 1 MB.

With translation off, the mapper gives an identity map: the processor address appears in the low 16 physical bits and every higher bit is zero. There is no access protection. Translation is combinational, and only the table and the enable bit are stored.

Top module: `pageMapper`

## Requirements
- R1: A synchronous active-high `rst` clears the enable bit and every table entry. After reset the output is the identity map, and turning translation on without loading the table maps every page to physical page 0.
- R2: While the enable bit is 0, `physAddr` equals `{8'h00, cpuAddr}`.
- R3: While the enable bit is 1, `physAddr[23:12]` equals the entry selected by `cpuAddr[15:12]`.
- R4: `physAddr[11:0]` always equals `cpuAddr[11:0]`, whatever the mode.
- R5: A rising edge with `mapSel`=1, `ctrlSel`=0 and `rwb`=0 loads entry number `cpuAddr[3:0]` with `{4'h0, dataIn}`, so `physAddr[23:20]` is always 0.
- R6: A rising edge with `ctrlSel`=1 and `rwb`=0 loads the enable bit from `dataIn[0]`. `dataIn[7:1]` has no effect.
- R7: When `rwb`=1, neither select changes the table or the enable bit.
- R8: When both selects are high together with `rwb`=0, only the enable bit is written and the table keeps its contents.
- R9: The output follows `cpuAddr` in the same cycle. A table or enable write changes the output only after the write edge.
- R10: The table keeps its contents while translation is off, and the same pages come back when translation is turned on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | 16 | Processor address. Its low 4 bits also give the entry number for a table write |
| rwb | input | 1 | 1 = read, 0 = write |
| mapSel | input | 1 | Select for a table-entry write |
| ctrlSel | input | 1 | Select for a control-word write |
| dataIn | input | 8 | Write data |
| physAddr | output | 24 | Translated physical address |

## Verification
The bench loads all sixteen entries with distinct page numbers and checks every page. A decode that took the entry number from the wrong address bits, or that swapped entries, would send pages to the wrong place. It writes the control word with the upper data bits set and bit 0 clear, and it drives writes with `rwb` high. A design that looked at the wrong data bit, or ignored `rwb`, would switch modes or corrupt entries. It raises both selects at once and then checks the table. A design that let the table select win would overwrite an entry. It also samples the output just before and just after a write edge, and it checks that the pages come back after the mapper has been disabled and enabled again. These catch a write that shows up too early and a disable that wipes the table.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  // Write strobes passed from the control module to the datapath.
  typedef struct packed {
    logic tableWr;  // load one translation entry
    logic ctrlWr;   // load the control word
  } mapStrobes_t;
endpackage

// File: rtl/pageMapCtrl.sv
module pageMapCtrl
  import pmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rwb,
  input  logic        mapSel,
  input  logic        ctrlSel,
  input  logic        enableBit,
  output mapStrobes_t strobes,
  output logic        enableQ
);
  logic writeCycle;

  assign writeCycle = ~rwb;

  // The control select wins when both selects are high.
  always_comb begin
    strobes.ctrlWr  = writeCycle & ctrlSel;
    strobes.tableWr = writeCycle & mapSel & ~ctrlSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= 1'b0;
    end else if (strobes.ctrlWr) begin
      enableQ <= enableBit;
    end
  end
endmodule

// File: rtl/pageMapData.sv
module pageMapData
  import pmap_pkg::*;
#(
  parameter int CPU_W    = 16,
  parameter int OFFSET_W = 12,
  parameter int ENTRY_W  = 12,
  parameter int LOAD_W   = 8,
  localparam int INDEX_W = CPU_W - OFFSET_W,
  localparam int ENTRIES = 1 << INDEX_W,
  localparam int PHYS_W  = ENTRY_W + OFFSET_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  mapStrobes_t                strobes,
  input  logic                       enableQ,
  input  logic [CPU_W-1:0]           cpuAddr,
  input  logic [LOAD_W-1:0]          dataIn,
  output logic [PHYS_W-1:0]          physAddr,
  output logic [ENTRIES*ENTRY_W-1:0] tableFlat
);
  localparam int PAD_W = ENTRY_W - LOAD_W;
  localparam int EXT_W = PHYS_W - CPU_W;

  logic [ENTRY_W-1:0] entryQ [ENTRIES];
  logic [INDEX_W-1:0] wrIndex;
  logic [INDEX_W-1:0] rdIndex;
  logic [ENTRY_W-1:0] loadWord;

  assign wrIndex  = cpuAddr[INDEX_W-1:0];
  assign rdIndex  = cpuAddr[CPU_W-1 -: INDEX_W];
  assign loadWord = {{PAD_W{1'b0}}, dataIn};

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (rst) begin
        entryQ[i] <= '0;
      end else if (strobes.tableWr && (wrIndex == INDEX_W'(i))) begin
        entryQ[i] <= loadWord;
      end
    end
    assign tableFlat[i*ENTRY_W +: ENTRY_W] = entryQ[i];
  end

  always_comb begin
    if (enableQ) begin
      physAddr = {entryQ[rdIndex], cpuAddr[OFFSET_W-1:0]};
    end else begin
      physAddr = {{EXT_W{1'b0}}, cpuAddr};
    end
  end
endmodule

// File: rtl/pageMapper.sv
module pageMapper
  import pmap_pkg::*;
#(
  parameter int CPU_W    = 16,
  parameter int OFFSET_W = 12,
  parameter int ENTRY_W  = 12,
  parameter int LOAD_W   = 8,
  localparam int INDEX_W = CPU_W - OFFSET_W,
  localparam int ENTRIES = 1 << INDEX_W,
  localparam int PHYS_W  = ENTRY_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_W-1:0]  cpuAddr,
  input  logic              rwb,
  input  logic              mapSel,
  input  logic              ctrlSel,
  input  logic [LOAD_W-1:0] dataIn,
  output logic [PHYS_W-1:0] physAddr
);
  mapStrobes_t               strobes;
  logic                      enableQ;
  logic [ENTRIES*ENTRY_W-1:0] tableFlat;

  pageMapCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .rwb       (rwb),
    .mapSel    (mapSel),
    .ctrlSel   (ctrlSel),
    .enableBit (dataIn[0]),
    .strobes   (strobes),
    .enableQ   (enableQ)
  );

  pageMapData #(
    .CPU_W    (CPU_W),
    .OFFSET_W (OFFSET_W),
    .ENTRY_W  (ENTRY_W),
    .LOAD_W   (LOAD_W)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .enableQ   (enableQ),
    .cpuAddr   (cpuAddr),
    .dataIn    (dataIn),
    .physAddr  (physAddr),
    .tableFlat (tableFlat)
  );
endmodule

// File: rtl/pageMapperChecker.sv
module pageMapperChecker #(
  parameter int CPU_W    = 16,
  parameter int OFFSET_W = 12,
  parameter int ENTRY_W  = 12,
  parameter int LOAD_W   = 8,
  localparam int INDEX_W = CPU_W - OFFSET_W,
  localparam int ENTRIES = 1 << INDEX_W,
  localparam int PHYS_W  = ENTRY_W + OFFSET_W,
  localparam int EXT_W   = PHYS_W - CPU_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic [CPU_W-1:0]           cpuAddr,
  input logic                       rwb,
  input logic                       mapSel,
  input logic                       ctrlSel,
  input logic                       newEnable,
  input logic                       enableQ,
  input logic [ENTRIES*ENTRY_W-1:0] tableFlat,
  input logic [PHYS_W-1:0]          physAddr
);
  AST_RESET_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (physAddr[PHYS_W-1:CPU_W] == '0)); // R1

  AST_DISABLED_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    !enableQ |-> (physAddr == {{EXT_W{1'b0}}, cpuAddr})); // R2

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    physAddr[OFFSET_W-1:0] == cpuAddr[OFFSET_W-1:0]); // R4

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    physAddr[PHYS_W-1 -: (ENTRY_W-LOAD_W)] == '0); // R5

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrlSel && !rwb) |=> (enableQ == $past(newEnable))); // R6

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    rwb |=> ($stable(tableFlat) && $stable(enableQ))); // R7

  AST_CTRL_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (ctrlSel && mapSel && !rwb) |=> $stable(tableFlat)); // R8
endmodule

bind pageMapper pageMapperChecker #(
  .CPU_W    (CPU_W),
  .OFFSET_W (OFFSET_W),
  .ENTRY_W  (ENTRY_W),
  .LOAD_W   (LOAD_W)
) uChecker (
  .clk       (clk),
  .rst       (rst),
  .cpuAddr   (cpuAddr),
  .rwb       (rwb),
  .mapSel    (mapSel),
  .ctrlSel   (ctrlSel),
  .newEnable (dataIn[0]),
  .enableQ   (enableQ),
  .tableFlat (tableFlat),
  .physAddr  (physAddr)
);

// File: tb/pageMapper_test.sv
module pageMapper_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic        rwb = 1'b1;
  logic        mapSel = 1'b0;
  logic        ctrlSel = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [23:0] physAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  pageMapper uut (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .rwb(rwb),
    .mapSel(mapSel), .ctrlSel(ctrlSel), .dataIn(dataIn), .physAddr(physAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: physAddr actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply an address and compare the combinational output.
  task automatic probe(input string req, input logic [15:0] a, input logic [23:0] exp);
    cpuAddr = a;
    #1;
    check(req, physAddr, exp);
  endtask

  function automatic logic [23:0] mapped(input logic [15:0] a);
    return {4'h0, model[a[15:12]], a[11:0]};
  endfunction

  task automatic busWrite(input logic tSel, input logic cSel, input logic rw,
                          input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    mapSel = tSel; ctrlSel = cSel; rwb = rw; cpuAddr = a; dataIn = d;
    @(negedge clk);
    mapSel = 1'b0; ctrlSel = 1'b0; rwb = 1'b1;
  endtask

  task automatic tReset();
    probe("R1", 16'h7123, 24'h007123);
    probe("R1", 16'hF00D, 24'h00F00D);
    busWrite(0, 1, 0, 16'h0000, 8'h01);
    probe("R1", 16'h5ABC, 24'h000ABC);
    busWrite(0, 1, 0, 16'h0000, 8'h00);
  endtask

  task automatic tIdentity();
    probe("R2", 16'h0000, 24'h000000);
    probe("R2", 16'hFFFF, 24'h00FFFF);
    probe("R4", 16'hA5C3, 24'h00A5C3);
  endtask

  task automatic tLoadAll();
    for (int i = 0; i < 16; i++) begin
      model[i] = 8'(8'hA5 ^ (i * 8'h13));
      busWrite(1, 0, 0, 16'(i), model[i]);
    end
    busWrite(0, 1, 0, 16'h0000, 8'h01);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = {4'(i), 12'(i * 12'h155 + 7)};
      probe("R3", a, mapped(a));
      check("R5", {20'h0, physAddr[23:20]}, 24'h0);
    end
    probe("R4", 16'h2FFF, {4'h0, model[2], 12'hFFF});
  endtask

  task automatic tWriteTiming();
    cpuAddr = 16'h3ABC;
    @(negedge clk);
    mapSel = 1'b1; rwb = 1'b0; cpuAddr = 16'h0003; dataIn = 8'h7E;
    #1;
    cpuAddr = 16'h3ABC; #1;
    check("R9 before edge", physAddr, {4'h0, model[3], 12'hABC});
    cpuAddr = 16'h0003;
    @(negedge clk);
    mapSel = 1'b0; rwb = 1'b1;
    model[3] = 8'h7E;
    probe("R9 after edge", 16'h3ABC, 24'h07EABC);
  endtask

  task automatic tCtrlBits();
    busWrite(0, 1, 0, 16'h1234, 8'hFE);
    probe("R6 upper bits ignored", 16'h9876, 24'h009876);
    busWrite(0, 1, 0, 16'h0000, 8'h01);
    probe("R6 enable", 16'h9876, mapped(16'h9876));
  endtask

  task automatic tReadIgnored();
    busWrite(1, 0, 1, 16'h0005, 8'h00);
    probe("R7 table", 16'h5111, mapped(16'h5111));
    busWrite(0, 1, 1, 16'h0000, 8'h00);
    probe("R7 enable", 16'hC222, mapped(16'hC222));
  endtask

  task automatic tPriority();
    busWrite(1, 1, 0, 16'h0002, 8'h00);
    probe("R8 ctrl written", 16'h2444, 24'h002444);
    busWrite(0, 1, 0, 16'h0000, 8'h01);
    probe("R8 table kept", 16'h2444, mapped(16'h2444));
  endtask

  task automatic tRetain();
    busWrite(0, 1, 0, 16'h0000, 8'h00);
    model[9] = 8'h3C;
    busWrite(1, 0, 0, 16'h0009, 8'h3C);
    probe("R10 identity while off", 16'h9555, 24'h009555);
    busWrite(0, 1, 0, 16'h0000, 8'h01);
    probe("R10 loaded while off", 16'h9555, mapped(16'h9555));
    probe("R10 kept", 16'hE666, mapped(16'hE666));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tIdentity();
    tLoadAll();
    tWriteTiming();
    tCtrlBits();
    tReadIgnored();
    tPriority();
    tRetain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule